// File: doc/BRIEF.md
# Two-Master Ownership Selector with Protection Freeze

This block decides which of two bus masters may configure a shared memory interface. It also holds the protection enables of that interface. Each master has its own write and read port. A master takes ownership by writing a keyed word to the select register at address 0. The upper thirty bits must carry a fixed key. The low two bits carry the requested owner code. Only the requesting master can place itself in charge, and an exclusive owner shuts the other master out.

Configuration writes to the protection, commit and lock registers are accepted only from the current owner. The protection enables stay writable until the commit bit is set. The commit bit stays writable until the lock bit is set. Both bits can only be set, and only reset clears them. A select write with a bad key changes nothing except a sticky key-error flag.

Top module: `own_ctrl`

## Requirements
- R1: After reset the owner code is 00, the protection enables, commit, lock and key-error are all 0, and cfg_wen is 01.
- R2: A write to address 0 is a valid select write only when wdata[31:2] equals 30'h24E9739C, that is, when the word reads 0x93A5CE7x with bits 3:2 at zero. The requested owner code is in wdata[1:0].
- R3: Owner codes 00, 01 and 11 give configuration rights to master 1 (cfg_wen = 01). Code 10 gives them to master 2 (cfg_wen = 10). owner_sel shows the code.
- R4: A master can only name itself. Master 1 cannot write code 10, and master 2 can only write code 10. A keyed write that breaks this rule has no effect.
- R5: While the code is 01, master 2 cannot take ownership. While the code is 10, master 1 cannot take ownership.
- R6: A read of address 0 returns the owner code in bits 1:0 and zeros above, never the key.
- R7: Writes to addresses 1, 2 and 3 from the master that is not the owner change no state.
- R8: Address 1 bits 2:0 hold the protection enables: bit 0 disables fetch, bit 1 disables CPU write, bit 2 disables DMA write. The owner can rewrite them only while the commit bit is 0. They read back at address 1.
- R9: The commit bit is address 2 bit 0 and the lock bit is address 3 bit 0. Writing 1 sets a bit and writing 0 does nothing. Commit cannot be set while lock is 1. Only reset clears either bit.
- R10: A write to address 0 with a wrong key leaves the owner unchanged and sets a sticky flag, read at address 4 bit 0. Only reset clears the flag.
- R11: When both masters make a valid select write in the same cycle, the one from master 1 takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| m1_we | input | 1 | Master 1 write strobe |
| m1_addr | input | ADDR_W | Master 1 register address |
| m1_wdata | input | DATA_W | Master 1 write data |
| m1_rdata | output | DATA_W | Master 1 read data for m1_addr |
| m2_we | input | 1 | Master 2 write strobe |
| m2_addr | input | ADDR_W | Master 2 register address |
| m2_wdata | input | DATA_W | Master 2 write data |
| m2_rdata | output | DATA_W | Master 2 read data for m2_addr |
| owner_sel | output | 2 | Current owner code |
| cfg_wen | output | 2 | Per-master configuration right (bit 0 master 1) |
| fetch_dis | output | 1 | Fetch disable enable |
| cpu_wr_dis | output | 1 | CPU write disable enable |
| dma_wr_dis | output | 1 | DMA write disable enable |

## Verification
The grab logic is tried four ways:
- with correct keys that carry each owner code;
- with keys off by one bit, including bit 2, which tells a real key compare apart from a compare on the upper nibbles only;
- with each master naming the other master;
- with both masters writing in the same cycle, which exposes the priority order.

Configuration writes come from the owner and from the non-owner, both before and after commit and lock. This separates owner gating from freeze gating. Setting lock before commit shows that lock freezes commit on its own. Random epochs, each started from reset, mix these patterns in arbitrary orders.

// File: rtl/own_pkg.sv
package own_pkg;
   localparam int OWN_W   = 2;
   localparam int SEL_ADDR    = 0;
   localparam int PROT_ADDR   = 1;
   localparam int COMMIT_ADDR = 2;
   localparam int LOCK_ADDR   = 3;
   localparam int KERR_ADDR   = 4;
   localparam logic [31:0] KEY_WORD = 32'h93A5CE70;

   typedef enum logic [OWN_W-1:0] {
      OWN_M1_OPEN0 = 2'b00,
      OWN_M1_EXCL  = 2'b01,
      OWN_M2_EXCL  = 2'b10,
      OWN_M1_OPEN1 = 2'b11
   } own_t;

   // bit 0 fetch, bit 1 cpu write, bit 2 dma write
   typedef struct packed {
      logic dma_wr;
      logic cpu_wr;
      logic fetch;
   } prot_t;

   localparam int PROT_W = $bits(prot_t);
endpackage

// File: rtl/own_arb.sv
module own_arb
   import own_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 3,
   parameter bit M2_EXCL_BLOCKS_M1 = 1'b1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [1:0]                   we,
   input  logic [1:0][ADDR_W-1:0]       addr,
   input  logic [1:0][DATA_W-1:0]       wdata,
   output own_t                         owner,
   output logic                         key_err
);
   logic [1:0] hit, key_ok, allow, take;

   for (genvar i = 0; i < 2; i++) begin : g_mst
      assign hit[i]    = we[i] && (addr[i] == ADDR_W'(SEL_ADDR));
      assign key_ok[i] = (wdata[i][DATA_W-1:2] == KEY_WORD[DATA_W-1:2]);
      assign take[i]   = hit[i] & key_ok[i] & allow[i];
   end

   // master 2 may only name itself and is shut out by master-1 exclusive
   assign allow[1] = (wdata[1][1:0] == OWN_M2_EXCL) && (owner != OWN_M1_EXCL);

   if (M2_EXCL_BLOCKS_M1) begin : g_sym
      assign allow[0] = (wdata[0][1:0] != OWN_M2_EXCL) && (owner != OWN_M2_EXCL);
   end else begin : g_asym
      assign allow[0] = (wdata[0][1:0] != OWN_M2_EXCL);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         owner   <= OWN_M1_OPEN0;
         key_err <= 1'b0;
      end else begin
         if (take[0])      owner <= own_t'(wdata[0][1:0]);
         else if (take[1]) owner <= own_t'(wdata[1][1:0]);
         if (|(hit & ~key_ok)) key_err <= 1'b1;
      end
   end

   AST_BADKEY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      ((|(hit & ~key_ok)) && !(|take)) |=> $stable(owner)); // R10
   AST_KERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      key_err |=> key_err); // R10
   AST_M2_SHUT_OUT: assert property (@(posedge clk) disable iff (!rst_n)
      (owner == OWN_M1_EXCL) |=> (owner != OWN_M2_EXCL)); // R5
   AST_M2_NAMES_OTHER: assert property (@(posedge clk) disable iff (!rst_n)
      (hit[1] && wdata[1][1:0] != OWN_M2_EXCL && !hit[0]) |=> $stable(owner)); // R4
   AST_M1_NAMES_OTHER: assert property (@(posedge clk) disable iff (!rst_n)
      (hit[0] && wdata[0][1:0] == OWN_M2_EXCL && !hit[1]) |=> $stable(owner)); // R4
endmodule

// File: rtl/own_prot.sv
module own_prot
   import own_pkg::*;
#(
   parameter int ADDR_W = 3
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [1:0]                   cfg_wen,
   input  logic [1:0]                   we,
   input  logic [1:0][ADDR_W-1:0]       addr,
   input  logic [1:0][PROT_W-1:0]       wdata,
   output prot_t                        prot,
   output logic                         commit,
   output logic                         lock
);
   logic [1:0]        own_hit;
   logic              ow_we;
   logic [ADDR_W-1:0] ow_addr;
   logic [PROT_W-1:0] ow_data;

   for (genvar i = 0; i < 2; i++) begin : g_gate
      assign own_hit[i] = we[i] & cfg_wen[i];
   end

   always_comb begin
      ow_we   = 1'b0;
      ow_addr = '0;
      ow_data = '0;
      for (int i = 0; i < 2; i++) begin
         if (own_hit[i]) begin
            ow_we   = 1'b1;
            ow_addr = addr[i];
            ow_data = wdata[i];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prot   <= '0;
         commit <= 1'b0;
         lock   <= 1'b0;
      end else if (ow_we) begin
         if (ow_addr == ADDR_W'(PROT_ADDR) && !commit)             prot   <= prot_t'(ow_data);
         if (ow_addr == ADDR_W'(COMMIT_ADDR) && !lock && ow_data[0]) commit <= 1'b1;
         if (ow_addr == ADDR_W'(LOCK_ADDR) && ow_data[0])           lock   <= 1'b1;
      end
   end

   AST_PROT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> $stable(prot)); // R8
   AST_COMMIT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      lock |=> $stable(commit)); // R9
   AST_LOCK_ONE_WAY: assert property (@(posedge clk) disable iff (!rst_n)
      lock |=> lock); // R9
   AST_FOREIGN_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (we[1] && !cfg_wen[1] && !we[0]) |=> ($stable(prot) && $stable(commit) && $stable(lock))); // R7
endmodule

// File: rtl/own_rd.sv
module own_rd
   import own_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 3
) (
   input  logic [ADDR_W-1:0] addr,
   input  own_t              owner,
   input  prot_t             prot,
   input  logic              commit,
   input  logic              lock,
   input  logic              key_err,
   output logic [DATA_W-1:0] rdata
);
   always_comb begin
      rdata = '0;
      case (addr)
         ADDR_W'(SEL_ADDR):    rdata = DATA_W'(owner);
         ADDR_W'(PROT_ADDR):   rdata = DATA_W'(prot);
         ADDR_W'(COMMIT_ADDR): rdata = DATA_W'(commit);
         ADDR_W'(LOCK_ADDR):   rdata = DATA_W'(lock);
         ADDR_W'(KERR_ADDR):   rdata = DATA_W'(key_err);
         default:              rdata = '0;
      endcase
   end
endmodule

// File: rtl/own_ctrl.sv
module own_ctrl
   import own_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 3,
   parameter bit M2_EXCL_BLOCKS_M1 = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              m1_we,
   input  logic [ADDR_W-1:0] m1_addr,
   input  logic [DATA_W-1:0] m1_wdata,
   output logic [DATA_W-1:0] m1_rdata,
   input  logic              m2_we,
   input  logic [ADDR_W-1:0] m2_addr,
   input  logic [DATA_W-1:0] m2_wdata,
   output logic [DATA_W-1:0] m2_rdata,
   output logic [1:0]        owner_sel,
   output logic [1:0]        cfg_wen,
   output logic              fetch_dis,
   output logic              cpu_wr_dis,
   output logic              dma_wr_dis
);
   initial begin
      assert (DATA_W == 32) else $fatal(1, "own_ctrl: DATA_W must be 32 for the key");
      assert (ADDR_W >= 3)  else $fatal(1, "own_ctrl: ADDR_W must reach address 4");
   end

   logic [1:0]              we_v;
   logic [1:0][ADDR_W-1:0]  addr_v;
   logic [1:0][DATA_W-1:0]  wdata_v;
   logic [1:0][PROT_W-1:0]  pdata_v;
   logic [1:0][DATA_W-1:0]  rdata_v;
   own_t                    owner;
   prot_t                   prot;
   logic                    commit, lock, key_err;

   assign we_v    = {m2_we, m1_we};
   assign addr_v  = {m2_addr, m1_addr};
   assign wdata_v = {m2_wdata, m1_wdata};

   for (genvar i = 0; i < 2; i++) begin : g_port
      assign pdata_v[i] = wdata_v[i][PROT_W-1:0];
      own_rd #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd (
         .addr(addr_v[i]), .owner(owner), .prot(prot), .commit(commit),
         .lock(lock), .key_err(key_err), .rdata(rdata_v[i]));
   end

   own_arb #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .M2_EXCL_BLOCKS_M1(M2_EXCL_BLOCKS_M1)) u_arb (
      .clk(clk), .rst_n(rst_n), .we(we_v), .addr(addr_v), .wdata(wdata_v),
      .owner(owner), .key_err(key_err));

   assign cfg_wen[1] = (owner == OWN_M2_EXCL);
   assign cfg_wen[0] = !cfg_wen[1];

   own_prot #(.ADDR_W(ADDR_W)) u_prot (
      .clk(clk), .rst_n(rst_n), .cfg_wen(cfg_wen), .we(we_v), .addr(addr_v),
      .wdata(pdata_v), .prot(prot), .commit(commit), .lock(lock));

   assign m1_rdata   = rdata_v[0];
   assign m2_rdata   = rdata_v[1];
   assign owner_sel  = owner;
   assign fetch_dis  = prot.fetch;
   assign cpu_wr_dis = prot.cpu_wr;
   assign dma_wr_dis = prot.dma_wr;
endmodule

// File: tb/sim_own_ctrl.sv
module sim_own_ctrl;
   localparam int AW = 3;
   localparam int DW = 32;
   localparam logic [31:0] KEY = 32'h93A5CE70;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic          m1_we = 0, m2_we = 0;
   logic [AW-1:0] m1_addr = '0, m2_addr = '0;
   logic [DW-1:0] m1_wdata = '0, m2_wdata = '0;
   logic [DW-1:0] m1_rdata, m2_rdata;
   logic [1:0]    owner_sel, cfg_wen;
   logic          fetch_dis, cpu_wr_dis, dma_wr_dis;

   own_ctrl u0 (
      .clk(clk), .rst_n(rst_n),
      .m1_we(m1_we), .m1_addr(m1_addr), .m1_wdata(m1_wdata), .m1_rdata(m1_rdata),
      .m2_we(m2_we), .m2_addr(m2_addr), .m2_wdata(m2_wdata), .m2_rdata(m2_rdata),
      .owner_sel(owner_sel), .cfg_wen(cfg_wen),
      .fetch_dis(fetch_dis), .cpu_wr_dis(cpu_wr_dis), .dma_wr_dis(dma_wr_dis));

   int n_chk = 0, n_bad = 0;
   bit done = 0;

   // reference state
   logic [1:0] e_own;
   logic [2:0] e_prot;
   logic       e_commit, e_lock, e_err;

   function automatic logic [31:0] exp_read(logic [AW-1:0] a);
      case (a)
         3'd0: return {30'b0, e_own};
         3'd1: return {29'b0, e_prot};
         3'd2: return {31'b0, e_commit};
         3'd3: return {31'b0, e_lock};
         3'd4: return {31'b0, e_err};
         default: return 32'b0;
      endcase
   endfunction

   function automatic bit key_good(logic [31:0] d);
      return d[31:2] == KEY[31:2];
   endfunction

   task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic check_all(string tag);
      check(tag, "owner_sel", {30'b0, owner_sel}, {30'b0, e_own});
      check(tag, "cfg_wen", {30'b0, cfg_wen}, {30'b0, (e_own == 2'b10), (e_own != 2'b10)});
      check(tag, "prot", {29'b0, dma_wr_dis, cpu_wr_dis, fetch_dis}, {29'b0, e_prot});
      check(tag, "m1_rdata", m1_rdata, exp_read(m1_addr));
      check(tag, "m2_rdata", m2_rdata, exp_read(m2_addr));
   endtask

   task automatic model_step(logic w1, logic [AW-1:0] a1, logic [31:0] d1,
                             logic w2, logic [AW-1:0] a2, logic [31:0] d2);
      logic [1:0] o = e_own;
      bit m1_owns = (o != 2'b10);
      bit t1 = w1 && a1 == 0 && key_good(d1) && d1[1:0] != 2'b10 && o != 2'b10;
      bit t2 = w2 && a2 == 0 && key_good(d2) && d2[1:0] == 2'b10 && o != 2'b01;
      logic wo; logic [AW-1:0] ao; logic [31:0] dd;
      if (t1) e_own = d1[1:0];
      else if (t2) e_own = 2'b10;
      if ((w1 && a1 == 0 && !key_good(d1)) || (w2 && a2 == 0 && !key_good(d2))) e_err = 1'b1;
      wo = m1_owns ? w1 : w2;
      ao = m1_owns ? a1 : a2;
      dd = m1_owns ? d1 : d2;
      if (wo && ao == 3'd1 && !e_commit) e_prot = dd[2:0];
      if (wo && ao == 3'd2 && !e_lock && dd[0]) e_commit = 1'b1;
      if (wo && ao == 3'd3 && dd[0]) e_lock = 1'b1;
   endtask

   task automatic cyc(string tag, logic w1, logic [AW-1:0] a1, logic [31:0] d1,
                      logic w2, logic [AW-1:0] a2, logic [31:0] d2);
      @(negedge clk);
      m1_we = w1; m1_addr = a1; m1_wdata = d1;
      m2_we = w2; m2_addr = a2; m2_wdata = d2;
      #1;
      check_all(tag);
      model_step(w1, a1, d1, w2, a2, d2);
   endtask

   task automatic idle(string tag, logic [AW-1:0] a1, logic [AW-1:0] a2);
      cyc(tag, 0, a1, 0, 0, a2, 0);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 0;
      m1_we = 0; m2_we = 0;
      e_own = 0; e_prot = 0; e_commit = 0; e_lock = 0; e_err = 0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1;
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog (all requirements): actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4711));
      do_reset();
      // R1 reset values
      idle("R1", 0, 4);
      idle("R1", 1, 2);
      idle("R1", 3, 4);
      // R3 R6 master 2 grabs exclusive
      cyc("R3", 0, 0, 0, 1, 0, KEY | 32'h2);
      idle("R6", 0, 0);
      // R5 master 1 blocked while master 2 exclusive
      cyc("R5", 1, 0, KEY | 32'h1, 0, 0, 0);
      idle("R5", 0, 0);
      // R7 master 1 not owner, prot write ignored; owner master 2 writes
      cyc("R7", 1, 1, 32'h7, 0, 1, 0);
      idle("R7", 1, 1);
      cyc("R8", 0, 1, 0, 1, 1, 32'h6);
      idle("R8", 1, 1);

      do_reset();
      // R4 naming the other master
      cyc("R4", 1, 0, KEY | 32'h2, 0, 0, 0);
      idle("R4", 0, 0);
      cyc("R4", 0, 0, 0, 1, 0, KEY | 32'h1);
      idle("R4", 0, 0);
      cyc("R4", 0, 0, 0, 1, 0, KEY | 32'h3);
      idle("R4", 0, 0);
      // R2 bit 2 set is not the key, R10 flag
      cyc("R2", 1, 0, KEY | 32'h5, 0, 0, 0);
      idle("R10", 4, 0);
      cyc("R2", 1, 0, 32'h13A5CE71, 0, 0, 0);
      idle("R2", 0, 4);
      // master 1 exclusive, master 2 shut out
      cyc("R6", 1, 0, KEY | 32'h1, 0, 0, 0);
      idle("R6", 0, 0);
      cyc("R5", 0, 0, 0, 1, 0, KEY | 32'h2);
      idle("R5", 0, 0);
      // R8 protection, R7 foreign write
      cyc("R8", 1, 1, 32'hFFFF_FFF5, 0, 0, 0);
      idle("R8", 1, 1);
      cyc("R7", 0, 0, 0, 1, 1, 32'h2);
      cyc("R7", 0, 0, 0, 1, 2, 32'h1);
      cyc("R7", 0, 0, 0, 1, 3, 32'h1);
      idle("R7", 2, 3);
      // R8 commit freezes protection
      cyc("R9", 1, 2, 32'h1, 0, 0, 0);
      cyc("R8", 1, 1, 32'h2, 0, 0, 0);
      idle("R8", 1, 2);
      cyc("R9", 1, 2, 32'h0, 0, 0, 0);
      idle("R9", 2, 2);

      do_reset();
      // R9 lock before commit freezes commit
      cyc("R9", 1, 3, 32'h1, 0, 0, 0);
      cyc("R9", 1, 2, 32'h1, 0, 0, 0);
      idle("R9", 2, 3);
      cyc("R9", 1, 3, 32'h0, 0, 0, 0);
      cyc("R8", 1, 1, 32'h3, 0, 0, 0);
      idle("R8", 3, 1);
      // R11 simultaneous grabs
      cyc("R11", 1, 0, KEY | 32'h3, 1, 0, KEY | 32'h2);
      idle("R11", 0, 0);
      cyc("R11", 1, 0, KEY | 32'h2, 1, 0, KEY | 32'h2);
      idle("R11", 0, 0);

      // random epochs
      for (int ep = 0; ep < 6; ep++) begin
         do_reset();
         for (int k = 0; k < 200; k++) begin
            logic [31:0] dv[2];
            logic [AW-1:0] av[2];
            logic wv[2];
            for (int m = 0; m < 2; m++) begin
               int kind = $urandom % 4;
               wv[m] = ($urandom % 8) < 5;
               av[m] = ($urandom % 10 < 6) ? AW'($urandom % 2) : AW'($urandom % 8);
               case (kind)
                  0, 1: dv[m] = KEY | 32'($urandom % 4);
                  2:    dv[m] = 32'($urandom % 8) | (($urandom % 16 == 0) ? 32'h1 : 32'h0);
                  default: dv[m] = (KEY | 32'($urandom % 4)) ^ (32'h4 << ($urandom % 28));
               endcase
               if (av[m] >= 2 && $urandom % 4 != 0) wv[m] = 0;
            end
            cyc("R3", wv[0], av[0], dv[0], wv[1], av[1], dv[1]);
         end
         idle("R10", 4, 0);
      end

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule